// File: doc/BRIEF.md
# Self-Checking Reconstruction Chain Controller

This block drives a chain of four combinational blocks. Each block takes an N-bit word, turns it into a vector of intermediate gate outputs, and then rebuilds the original word from that vector. A step register supplies the word at the head of the chain. An adder adds a step value K to the register. An equality comparator checks the chain's output word against the register. Because a fault-free chain always returns its own input, any mismatch points to a logic error somewhere in the active blocks.

The controller has four modes. In synchronous mode the register advances on every clock edge. In self-timed mode the comparator's match output is the advance enable, so a logic error freezes the sequence at the failing word. Diagnosis mode leaves a single selected block active and routes around the rest, which localises a fault to one block. Loopback mode routes around every block. A sticky error flag records the first mismatch and the register value at which it occurred. A fault in one block can be built in at elaboration through parameters, which lets a test instance carry a known defect.

Top module: `chain_ctrl`

## Requirements
- R1: While reset is asserted, and after its release, the step register is 0, `err_flag` is 0 and `err_value` is 0.
- R2: With `mode` = 2'b00 (synchronous), every clock edge adds `step_k` to the register modulo 2^N, whether or not the comparison matches.
- R3: With `mode` = 2'b01 (self-timed), every block is active, and the register adds `step_k` on a clock edge only when `int_ck` is high; otherwise it holds its value.
- R4: `int_ck` is high exactly when `chain_out` equals the current register value.
- R5: On the first clock edge where `int_ck` is low, `err_flag` becomes 1 and `err_value` takes the register value present at that edge. This applies in every mode.
- R6: Once set, `err_flag` and `err_value` hold until reset.
- R7: With `mode` = 2'b10 (diagnosis), only the block whose index equals `blk_sel` is active and every other block is bypassed. The register advances as in R3. A faulty block is therefore identified as the only selection that raises `err_flag`.
- R8: With `mode` = 2'b11 (loopback), every block is bypassed and `chain_out` equals the register value.
- R9: A fault-free block returns its input word unchanged for all 2^N input values, so a fault-free chain never mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_k | input | N | Step value added to the register |
| mode | input | 2 | 00 synchronous, 01 self-timed, 10 diagnosis, 11 loopback |
| blk_sel | input | clog2(BLOCKS) | Block left active in diagnosis mode |
| chain_out | output | N | Word leaving the last chain stage |
| int_ck | output | 1 | Match indication; advance enable in self-timed modes |
| err_flag | output | 1 | Sticky first-mismatch flag |
| err_value | output | N | Register value at the first mismatch |

## Verification
Two instances run side by side: a fault-free one, and one whose third block has bit 1 of its rebuilt word stuck at 0. All modes, all block selections and all eight step values are swept. The bench targets the following errors. A design that advanced on a mismatch in a self-timed mode would run past the failing word. A design that latched the word after the step, rather than the word at the failing edge, would report the wrong `err_value`. A design that froze the synchronous sequence on a mismatch would be wrong, because that sequence must keep counting. A decoder that enabled the wrong block, or more than one block, in diagnosis would blame a healthy block or miss the faulty one. A step of 0 checks that the register holds while no error appears. A step of 3 reaches the failing word by a different path.

// File: rtl/chain_pkg.sv
package chain_pkg;
   typedef enum logic [1:0] {
      MODE_SYNC = 2'b00,
      MODE_FREE = 2'b01,
      MODE_DIAG = 2'b10,
      MODE_LOOP = 2'b11
   } mode_e;
endpackage

// File: rtl/recon_block.sv
module recon_block #(
   parameter int N         = 3,
   parameter bit FAULT_EN  = 1'b0,
   parameter int FAULT_BIT = 0,
   parameter bit FAULT_VAL = 1'b0
) (
   input  logic [N-1:0] x,
   output logic [N-1:0] y
);
   initial begin
      if (N < 2) $error("recon_block: N must be at least 2");
      if (FAULT_BIT < 0 || FAULT_BIT >= N) $error("recon_block: FAULT_BIT out of range");
   end

   logic [N-1:0] w;      // first stage: one gate level fed by the inputs
   logic [N-1:0] rebuilt;

   generate
      for (genvar i = 0; i < N - 1; i++) begin : g_pair
         assign w[i] = ~(x[i] ^ x[i+1]);
      end
   endgenerate
   assign w[N-1] = ~x[N-1];

   // second stage: unwind the xnor ladder from the top bit down
   assign rebuilt[N-1] = ~w[N-1];
   generate
      for (genvar i = N - 2; i >= 0; i--) begin : g_unwind
         assign rebuilt[i] = ~(w[i] ^ rebuilt[i+1]);
      end
   endgenerate

   generate
      if (FAULT_EN) begin : g_fault
         always_comb begin
            y = rebuilt;
            y[FAULT_BIT] = FAULT_VAL;
         end
      end else begin : g_clean
         assign y = rebuilt;
      end
   endgenerate
endmodule

// File: rtl/blk_decoder.sv
module blk_decoder
   import chain_pkg::*;
#(
   parameter int BLOCKS = 4,
   localparam int SW = $clog2(BLOCKS)
) (
   input  mode_e           mode,
   input  logic [SW-1:0]   sel,
   output logic [BLOCKS-1:0] active
);
   always_comb begin
      unique case (mode)
         MODE_SYNC, MODE_FREE: active = '1;
         MODE_DIAG: begin
            active = '0;
            for (int b = 0; b < BLOCKS; b++)
               if (sel == SW'(b)) active[b] = 1'b1;
         end
         default: active = '0;
      endcase
   end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
   import chain_pkg::*;
#(
   parameter int N           = 3,
   parameter int BLOCKS      = 4,
   parameter int FAULT_BLOCK = -1,
   parameter int FAULT_BIT   = 1,
   parameter bit FAULT_VAL   = 1'b0,
   localparam int SW = $clog2(BLOCKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  step_k,
   input  logic [1:0]    mode,
   input  logic [SW-1:0] blk_sel,
   output logic [N-1:0]  chain_out,
   output logic          int_ck,
   output logic          err_flag,
   output logic [N-1:0]  err_value
);
   initial begin
      if (BLOCKS < 2) $error("chain_ctrl: BLOCKS must be at least 2");
      if (FAULT_BLOCK >= BLOCKS) $error("chain_ctrl: FAULT_BLOCK out of range");
   end

   mode_e              mode_i;
   logic [N-1:0]       cnt_q;
   logic [BLOCKS-1:0]  active;
   logic [N-1:0]       stage [BLOCKS+1];
   logic               advance;

   assign mode_i = mode_e'(mode);

   blk_decoder #(.BLOCKS(BLOCKS)) u_dec (
      .mode  (mode_i),
      .sel   (blk_sel),
      .active(active)
   );

   assign stage[0] = cnt_q;
   generate
      for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
         logic [N-1:0] y;
         recon_block #(
            .N        (N),
            .FAULT_EN (b == FAULT_BLOCK),
            .FAULT_BIT(FAULT_BIT),
            .FAULT_VAL(FAULT_VAL)
         ) u_blk (
            .x(stage[b]),
            .y(y)
         );
         assign stage[b+1] = active[b] ? y : stage[b];
      end
   endgenerate

   assign chain_out = stage[BLOCKS];
   assign int_ck    = (chain_out == cnt_q);
   assign advance   = (mode_i == MODE_SYNC) ? 1'b1 : int_ck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         err_flag  <= 1'b0;
         err_value <= '0;
      end else begin
         if (advance) cnt_q <= cnt_q + step_k;
         if (!int_ck && !err_flag) begin
            err_flag  <= 1'b1;
            err_value <= cnt_q;
         end
      end
   end
endmodule

// File: rtl/chain_ctrl_chk.sv
module chain_ctrl_chk #(
   parameter int N      = 3,
   parameter int BLOCKS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      step_k,
   input logic [1:0]        mode,
   input logic [N-1:0]      chain_out,
   input logic              int_ck,
   input logic              err_flag,
   input logic [N-1:0]      err_value,
   input logic [N-1:0]      cnt,
   input logic [BLOCKS-1:0] active
);
   logic [N-1:0] nxt;
   assign nxt = cnt + step_k;

   p_sync_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (cnt == $past(nxt)));

   p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && int_ck) |=> (cnt == $past(nxt)));

   p_hold_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && !int_ck) |=> $stable(cnt));

   p_err_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_ck && !err_flag) |=> (err_flag && err_value == $past(cnt)));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> (err_flag && $stable(err_value)));

   p_diag_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> ($countones(active) == 1));

   p_loop_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> (chain_out == cnt));
endmodule

bind chain_ctrl chain_ctrl_chk #(.N(N), .BLOCKS(BLOCKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .step_k(step_k), .mode(mode),
   .chain_out(chain_out), .int_ck(int_ck), .err_flag(err_flag),
   .err_value(err_value), .cnt(cnt_q), .active(active)
);

// File: tb/chain_ctrl_tb.sv
module chain_ctrl_tb;
   localparam int N = 3;
   localparam int BLOCKS = 4;
   localparam int FB = 2;          // faulty block index in the second instance
   localparam logic [N-1:0] FMASK = 3'b010;  // bit 1 stuck at 0

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] step_k = '0;
   logic [1:0] mode = 2'b00;
   logic [1:0] blk_sel = '0;
   logic [N-1:0] out_a, out_b, ev_a, ev_b;
   logic ck_a, ck_b, ef_a, ef_b;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   chain_ctrl #(.N(N), .BLOCKS(BLOCKS)) u_dut (
      .clk(clk), .rst_n(rst_n), .step_k(step_k), .mode(mode), .blk_sel(blk_sel),
      .chain_out(out_a), .int_ck(ck_a), .err_flag(ef_a), .err_value(ev_a));

   chain_ctrl #(.N(N), .BLOCKS(BLOCKS), .FAULT_BLOCK(FB), .FAULT_BIT(1), .FAULT_VAL(1'b0)) u_dut_flt (
      .clk(clk), .rst_n(rst_n), .step_k(step_k), .mode(mode), .blk_sel(blk_sel),
      .chain_out(out_b), .int_ck(ck_b), .err_flag(ef_b), .err_value(ev_b));

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (mode %0d sel %0d k %0d)",
                  req, act, exp, mode, blk_sel, step_k);
      end
   endtask

   // chain output of the model: the faulty block clears bit 1 when active
   function automatic logic [N-1:0] model_out(input logic [N-1:0] c, input bit faulty);
      bit fb_active;
      fb_active = (mode == 2'b00) || (mode == 2'b01) || (mode == 2'b10 && blk_sel == 2'(FB));
      return (faulty && fb_active) ? (c & ~FMASK) : c;
   endfunction

   function automatic string mode_req();
      case (mode)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset out", int'(out_a), 0);
      chk("R1 reset flag", int'(ef_a), 0);
      chk("R1 reset value", int'(ev_b), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int cycles);
      logic [N-1:0] c [2];
      logic e [2];
      logic [N-1:0] v [2];
      logic [N-1:0] mo;
      for (int d = 0; d < 2; d++) begin c[d] = '0; e[d] = 1'b0; v[d] = '0; end
      for (int t = 0; t < cycles; t++) begin
         for (int d = 0; d < 2; d++) begin
            mo = model_out(c[d], d == 1);
            chk({mode_req(), " out"}, int'(d == 0 ? out_a : out_b), int'(mo));
            chk("R4 int_ck", int'(d == 0 ? ck_a : ck_b), int'(mo == c[d]));
            chk("R5 err_flag", int'(d == 0 ? ef_a : ef_b), int'(e[d]));
            chk("R6 err_value", int'(d == 0 ? ev_a : ev_b), int'(v[d]));
            if (mo != c[d] && !e[d]) begin e[d] = 1'b1; v[d] = c[d]; end
            if (mode == 2'b00 || mo == c[d]) c[d] = c[d] + step_k;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int found;
      int hits;
      // R9: fault-free chain in sync mode with K=1 visits every word and matches each
      mode = 2'b00; step_k = 3'd1;
      do_reset();
      for (int t = 0; t < 8; t++) begin
         chk("R9 rebuild", int'(out_a), t);
         @(negedge clk);
      end
      // near-exhaustive sweep: every mode, selection and step
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 4; s++)
            for (int k = 0; k < 8; k++) begin
               mode = 2'(m); blk_sel = 2'(s); step_k = 3'(k);
               do_reset();
               run(10);
            end
      // R7: diagnosis with K=1 flags only the faulty block
      found = -1; hits = 0;
      mode = 2'b10; step_k = 3'd1;
      for (int s = 0; s < 4; s++) begin
         blk_sel = 2'(s);
         do_reset();
         repeat (8) @(negedge clk);
         if (ef_b) begin found = s; hits++; end
         chk("R7 healthy never flags", int'(ef_a), 0);
      end
      chk("R7 faulty block located", found, FB);
      chk("R7 single suspect", hits, 1);
      // R3: self-timed run stops at the failing word 2 with K=1
      mode = 2'b01; step_k = 3'd1;
      do_reset();
      repeat (6) @(negedge clk);
      chk("R3 stop word", int'(out_b), 0);
      chk("R5 failing word", int'(ev_b), 2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule